// File: doc/BRIEF.md
# Fixed-Point Double-Scroll Chaotic Oscillator

This block iterates a three-variable piecewise-linear chaotic system of the double-scroll kind. It keeps the state in signed 32-bit fixed point with 20 fraction bits and advances it with a forward-Euler step of 2^-7. The step is taken as an arithmetic right shift, so no multiplier is spent on it. The dynamics are dx = a*(y - x - f(x)), dy = x - y + z and dz = b*y. The nonlinear response is f(x) = s1*x + ((s0 - s1)/2)*(|x+1| - |x-1|).

A single strobe captures a 224-bit key word. The key holds the two gains, the two slopes and the three starting states, and it is treated as secret material for a downstream whitening stage. From the cycle after the strobe, the block presents the first state variable as a full 32-bit word with a valid flag. It computes a new sample on every following clock.

A typical operating point is a = 15.6, b = -36, s0 = -9/7 and s1 = -4/7. A typical start is x = 0.9654454, y = 1.0029554 and z = 1.4597855. Each of these values is rounded to the nearest 2^-20.

Top module: `scroll_osc`

## Requirements
- R1: While reset is high and on the cycle after it, xValid is 0 and xOut is 0. Reset is synchronous and active high.
- R2: keyBus is split into seven 32-bit words, with word k at bits [32k+31:32k]. Word 0 is gain a, word 1 is gain b, word 2 is slope s0, word 3 is slope s1, word 4 is the starting x, word 5 is the starting y and word 6 is the starting z. Every word is signed with 20 fraction bits.
- R3: A high load on a clock edge captures the whole key. In the next cycle xValid is 1 and xOut equals key word 4.
- R4: Before any load, xOut and xValid hold their reset values and do not change.
- R5: While valid and without load, each edge sets x to x + (dx >>> 7), y to y + (dy >>> 7) and z to z + (dz >>> 7). All three use the old state.
- R6: Every product is formed at 64 bits from the sign-extended operands, shifted arithmetically right by 20, and kept to its low 32 bits.
- R7: The nonlinearity is f(x) = s1*x + ((s0 - s1) >>> 1)*(|x + 2^20| - |x - 2^20|), with both products as in R6.
- R8: All sums, differences and absolute values wrap in 32-bit two's complement.
- R9: A load while running discards the current state. The run restarts from the newly captured key, following R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Key capture strobe |
| keyBus | input | 224 | Gains, slopes and starting states, seven words |
| xOut | output | 32 | Current x sample, signed Q11.20 |
| xValid | output | 1 | xOut holds a live sample |

## Verification
The bench compares xOut against an integer model of the equations for 1200 consecutive steps at the usual chaotic operating point. Because the trajectory is chaotic, any error in the product truncation, in the slope halving or in the step shift diverges within a few dozen steps and is caught.

A second key uses gains large enough to overflow every product and sum. A design that saturated, or kept extra width, would part from the wrapping model at once.

The bench also checks three timing cases:
- A reload in the middle of a run must restart exactly from the new start. A design that blended the old state would show a wrong first sample.
- An idle stretch before the first load must keep xOut flat. A free-running design would move it.
- The sample in the cycle just after the load strobe must equal the starting x. A design with an extra pipeline stage would be one cycle late.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  parameter int unsigned WORD = 32;
  parameter int unsigned FRAC = 20;
  parameter int unsigned STEP = 7;
  parameter int unsigned NKEY = 7;
  localparam int unsigned KEYW = WORD * NKEY;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/scroll_ctrl.sv
module scroll_ctrl (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  output scroll_pkg::strobe_t strobes,
  output logic                running
);
  always_ff @(posedge clk) begin
    if (rst)       running <= 1'b0;
    else if (load) running <= 1'b1;
  end

  always_comb begin
    strobes.capture = load && !rst;
    strobes.advance = running && !load && !rst;
  end

  // R3
  // load_sets_valid_chk
  load_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> running);

  // R1
  // reset_clears_chk
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !running);

  // R9
  // strobe_excl_chk
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));
endmodule

// File: rtl/scroll_dpath.sv
module scroll_dpath
  import scroll_pkg::*;
#(
  parameter int unsigned W     = WORD,
  parameter int unsigned FB    = FRAC,
  parameter int unsigned SH    = STEP,
  parameter int unsigned KW    = KEYW
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [KW-1:0]    keyBus,
  output logic [W-1:0]     xState
);
  localparam int unsigned PW = 2 * W;
  localparam logic signed [W-1:0] ONE = W'(1) <<< FB;

  typedef logic signed [W-1:0] fix_t;

  fix_t xR, yR, zR, gA, gB, s0R, s1R;
  fix_t fNl, dX, dY, dZ, halfSlope, absP, absM, vP, vM;

  function automatic fix_t fmul(input fix_t a, input fix_t b);
    logic signed [PW-1:0] p;
    p = PW'(a) * PW'(b);
    p = p >>> FB;
    return fix_t'(p[W-1:0]);
  endfunction

  function automatic fix_t fabs(input fix_t v);
    return v[W-1] ? -v : v;
  endfunction

  fix_t kw [NKEY];
  generate
    for (genvar k = 0; k < NKEY; k++) begin : g_key
      assign kw[k] = fix_t'(keyBus[k*W +: W]);
    end
  endgenerate

  always_comb begin
    vP        = xR + ONE;
    vM        = xR - ONE;
    absP      = fabs(vP);
    absM      = fabs(vM);
    halfSlope = (s0R - s1R) >>> 1;
    fNl       = fmul(s1R, xR) + fmul(halfSlope, absP - absM);
    dX        = fmul(gA, yR - xR - fNl);
    dY        = xR - yR + zR;
    dZ        = fmul(gB, yR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xR <= '0; yR <= '0; zR <= '0;
      gA <= '0; gB <= '0; s0R <= '0; s1R <= '0;
    end else if (strobes.capture) begin
      gA  <= kw[0]; gB  <= kw[1];
      s0R <= kw[2]; s1R <= kw[3];
      xR  <= kw[4]; yR  <= kw[5]; zR <= kw[6];
    end else if (strobes.advance) begin
      xR <= xR + (dX >>> SH);
      yR <= yR + (dY >>> SH);
      zR <= zR + (dZ >>> SH);
    end
  end

  assign xState = xR;

  // R4
  // hold_when_idle_chk
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.capture && !strobes.advance) |=> $stable(xR));

  // R3
  // capture_start_chk
  capture_start_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> xR == $past(kw[4]));

  // R1
  // reset_zero_chk
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> xR == '0);
endmodule

// File: rtl/scroll_osc.sv
module scroll_osc (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [223:0] keyBus,
  output logic [31:0]  xOut,
  output logic         xValid
);
  import scroll_pkg::*;

  strobe_t strobes;

  scroll_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .strobes (strobes),
    .running (xValid)
  );

  scroll_dpath u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .keyBus  (keyBus),
    .xState  (xOut)
  );

  // R3
  // valid_out_chk
  valid_out_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (xValid && xOut == $past(keyBus[159:128])));
endmodule

// File: tb/scroll_osc_test.sv
module scroll_osc_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [223:0] keyBus = '0;
  logic [31:0]  xOut;
  logic         xValid;

  int checks = 0;
  int errors = 0;
  int mx, my, mz, ma, mb, m0, m1;
  logic done = 1'b0;

  scroll_osc uut (.clk(clk), .rst(rst), .load(load), .keyBus(keyBus),
                  .xOut(xOut), .xValid(xValid));

  always #5 clk = ~clk;

  function automatic int qmul(int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    p = p >>> 20;
    return int'(p);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // R5 R6 R7 R8 reference step
  task automatic refStep();
    int f, dx, dy, dz;
    f  = qmul(m1, mx) + qmul((m0 - m1) >>> 1, iabs(mx + (1 << 20)) - iabs(mx - (1 << 20)));
    dx = qmul(ma, my - mx - f);
    dy = mx - my + mz;
    dz = qmul(mb, my);
    mx = mx + (dx >>> 7);
    my = my + (dy >>> 7);
    mz = mz + (dz >>> 7);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 key layout
  task automatic doLoad(int a, int b, int s0, int s1, int x0, int y0, int z0);
    keyBus = {z0, y0, x0, s1, s0, b, a};
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    ma = a; mb = b; m0 = s0; m1 = s1; mx = x0; my = y0; mz = z0;
    check("R3 valid", 32'(xValid), 32'd1);
    check("R3 start", xOut, mx);
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      refStep();
      check(req, xOut, mx);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(xValid), 32'd0);
    check("R1 x", xOut, 32'd0);
    rst = 1'b0;
    keyBus = {7{32'h1234_5678}};
    repeat (5) @(negedge clk);
    check("R4 idle valid", 32'(xValid), 32'd0);
    check("R4 idle x", xOut, 32'd0);

    doLoad(16357786, -37748736, -1348169, -599186, 1012343, 1051675, 1530696);
    run(1200, "R5 R6 R7 trajectory");

    // R9 reload mid-run
    doLoad(16357786, -37748736, -1348169, -599186, -2097152, 524288, -1048576);
    run(300, "R9 restart trajectory");

    // R8 wrap with large gains
    doLoad(32'h7fff_0000, 32'h8000_1000, 32'h7000_0000, -32'h7000_0000,
           32'h6000_0000, -32'h5000_0000, 32'h7fff_ffff);
    run(200, "R8 wrap trajectory");

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 after reset valid", 32'(xValid), 32'd0);
    check("R1 after reset x", xOut, 32'd0);
    repeat (3) @(negedge clk);
    check("R4 hold after reset", xOut, 32'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule